// File: doc/BRIEF.md
# Burst Address Generator for a Synchronous RAM Port

This block sits in front of one port of a synchronous RAM and supplies the address used for each access. The address comes either from the external address pins or from an internal counter. The counter can be cleared to zero, loaded from the pins, held, or stepped up by one.

Three active-low controls are sampled on the rising clock edge: clear, strobe and step. Clear overrides strobe, and strobe overrides step. The access address for a cycle is the value the counter takes at the end of that cycle. A clear, load or step therefore adds no dead cycle. The RAM sees the new address in the same cycle, so a clear cycle accesses address 0 and a step cycle accesses the next address.

The address width is a parameter, normally 15, 16 or 17 bits. The block ignores the chip selects entirely.

Top module: `burst_addr_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the counter (`cnt_q`) becomes 0 on that edge.
- R2: When `clr_n` is low, `access_addr` is 0 and `cnt_q` becomes 0 at the edge. This holds whatever `ld_n` and `inc_n` are.
- R3: When `clr_n` is high and `ld_n` is low, `access_addr` equals `ext_addr` and `cnt_q` takes that value at the edge. The level of `inc_n` has no effect in this case.
- R4: When `clr_n` and `ld_n` are high and `inc_n` is low, `access_addr` is `cnt_q + 1` and `cnt_q` takes that value at the edge.
- R5: When `clr_n`, `ld_n` and `inc_n` are all high, `access_addr` equals `cnt_q` and the counter keeps its value. `ext_addr` is ignored.
- R6: A step from the all-ones address gives 0, both on `access_addr` and in the counter.
- R7: After each edge where `rst` is low, `cnt_q` equals the `access_addr` that was present before that edge, so there is no dead cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | ADDR_W | External address pins |
| clr_n | input | 1 | Active-low counter clear, highest priority |
| ld_n | input | 1 | Active-low address strobe, loads `ext_addr` |
| inc_n | input | 1 | Active-low step enable |
| access_addr | output | ADDR_W | Address used by the RAM this cycle (combinational) |
| cnt_q | output | ADDR_W | Registered counter value |

## Verification
The assertions take `clr_n`, `ld_n`, `inc_n` and `ext_addr` to be known, stable values across each rising edge, and `rst` to be high at the first edge. The bench changes every input only on the falling edge and holds reset for the first two edges. It drives every combination of the three controls, including the ones where a lower-priority control is active together with a higher one, so the priority order is exercised.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } bac_op_e;
endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import burst_addr_pkg::*;
(
  input  logic    clr_n,
  input  logic    ld_n,
  input  logic    inc_n,
  output bac_op_e op
);
  // Fixed priority: clear, then load, then step, else hold.
  always_comb begin
    if (!clr_n)      op = OP_CLEAR;
    else if (!ld_n)  op = OP_LOAD;
    else if (!inc_n) op = OP_STEP;
    else             op = OP_HOLD;
  end
endmodule

// File: rtl/bac_next.sv
module bac_next
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  bac_op_e           op,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] ext,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = ext;
      OP_STEP:  nxt = cur + ONE;  // natural wrap at all-ones
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/bac_reg.sv
module bac_reg #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              clr_n,
  input  logic              ld_n,
  input  logic              inc_n,
  output logic [ADDR_W-1:0] access_addr,
  output logic [ADDR_W-1:0] cnt_q
);
  bac_op_e           op;
  logic [ADDR_W-1:0] nxt;

  bac_decode u_dec (
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .inc_n (inc_n),
    .op    (op)
  );

  bac_next #(.ADDR_W(ADDR_W)) u_nxt (
    .op  (op),
    .cur (cnt_q),
    .ext (ext_addr),
    .nxt (nxt)
  );

  bac_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (nxt),
    .q   (cnt_q)
  );

  // The access of this cycle already uses the value being committed.
  assign access_addr = nxt;
endmodule

// File: rtl/bac_checker.sv
module bac_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              clr_n,
  input logic              ld_n,
  input logic              inc_n,
  input logic [ADDR_W-1:0] access_addr,
  input logic [ADDR_W-1:0] cnt_q
);
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> cnt_q == '0);

  a_r2_clear_addr: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> access_addr == '0);

  a_r2_clear_cnt: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> cnt_q == '0);

  a_r3_load_addr: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !ld_n) |-> access_addr == ext_addr);

  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && !inc_n) |=> cnt_q == ADDR_W'($past(cnt_q) + ADDR_W'(1)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && inc_n) |=> $stable(cnt_q));

  a_r7_no_dead_cycle: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt_q == $past(access_addr));
endmodule

bind burst_addr_counter bac_checker #(.ADDR_W(ADDR_W)) u_bac_checker (
  .clk         (clk),
  .rst         (rst),
  .ext_addr    (ext_addr),
  .clr_n       (clr_n),
  .ld_n        (ld_n),
  .inc_n       (inc_n),
  .access_addr (access_addr),
  .cnt_q       (cnt_q)
);

// File: tb/burst_addr_counter_bench.sv
module burst_addr_counter_bench;
  localparam int AW = 17;
  localparam logic [AW-1:0] ALL1 = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          clr_n = 1'b1, ld_n = 1'b1, inc_n = 1'b1;
  logic [AW-1:0] access_addr, cnt_q;

  int n_chk = 0;
  int n_bad = 0;
  logic [AW-1:0] model = '0;

  always #5 clk = ~clk;

  burst_addr_counter #(.ADDR_W(AW)) u_burst_addr_counter (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .clr_n(clr_n),
    .ld_n(ld_n), .inc_n(inc_n), .access_addr(access_addr), .cnt_q(cnt_q)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle. Check the access address before the edge and the
  // counter after it, against the priority model: clear > load > step > hold.
  task automatic cyc(input string req, input logic c, input logic l,
                     input logic i, input logic [AW-1:0] a);
    logic [AW-1:0] e;
    @(negedge clk);
    clr_n = c; ld_n = l; inc_n = i; ext_addr = a;
    if (!c)      e = '0;
    else if (!l) e = a;
    else if (!i) e = model + AW'(1);
    else         e = model;
    #1 chk({req, " access"}, access_addr, e);
    @(posedge clk); #1;
    model = e;
    chk({req, " counter"}, cnt_q, e);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk("R1 reset", cnt_q, '0);
    @(negedge clk); rst = 1'b0;
    model = '0;
  endtask

  task automatic t_load;
    cyc("R3 load", 1, 0, 1, 17'h0_1234);
    cyc("R3 load ignores step", 1, 0, 0, 17'h1_5555);
    cyc("R7 load then hold", 1, 1, 1, 17'h0_0000);
  endtask

  task automatic t_step;
    cyc("R3 load base", 1, 0, 1, 17'h0_00F0);
    for (int k = 0; k < 5; k++) cyc("R4 step", 1, 1, 0, 17'h1_AAAA);
  endtask

  task automatic t_hold;
    cyc("R5 hold", 1, 1, 1, 17'h1_7777);
    cyc("R5 hold ext ignored", 1, 1, 1, 17'h0_3C3C);
    chk("R5 hold value", cnt_q, 17'h0_00F5);
  endtask

  task automatic t_clear;
    cyc("R2 clear alone", 0, 1, 1, 17'h0_4444);
    cyc("R3 reload", 1, 0, 1, 17'h0_0999);
    cyc("R2 clear beats load", 0, 0, 1, 17'h1_2222);
    cyc("R3 reload", 1, 0, 1, 17'h0_0888);
    cyc("R2 clear beats step", 0, 1, 0, 17'h0_0001);
    cyc("R2 clear beats all", 0, 0, 0, 17'h1_FFFE);
    cyc("R7 step after clear", 1, 1, 0, 17'h0_0000);
    chk("R7 step after clear value", cnt_q, 17'h0_0001);
  endtask

  task automatic t_wrap;
    cyc("R6 load top-1", 1, 0, 1, ALL1 - AW'(1));
    cyc("R6 step to top", 1, 1, 0, 17'h0_0000);
    cyc("R6 wrap", 1, 1, 0, 17'h0_0000);
    chk("R6 wrap value", cnt_q, '0);
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_step();
    t_hold();
    t_clear();
    t_wrap();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule